// File: doc/BRIEF.md
# Observation Queue and Unit Dispatcher

This block sits between an event filter and a pool of small processing units that compute prefetch addresses. Each arriving observation carries a virtual address, a handler start address and an optional cache line payload. Observations wait in a ring buffer until a unit is idle. The oldest waiting observation is then handed to the lowest-numbered idle unit: the payload and handler address appear on a shared dispatch bus, and that unit receives a one-cycle start pulse.

A unit stays busy until it reports completion or a fault. The producer is never stalled. When the ring is full and nothing leaves in that cycle, the newest arrival overwrites the oldest entry and a drop counter steps. A context-switch flush empties the ring, aborts every running unit and returns the whole pool to idle.

Top module: `obs_dispatch`

## Requirements
- R1: After reset all units are idle, no start pulse or abort is shown, the ring is empty and the drop counter reads 0.
- R2: An observation accepted into an empty ring while a unit is idle produces that unit's start pulse one clock later. The pulse lasts exactly one cycle.
- R3: The start pulse appears together with the observation's address on `disp_vaddr`, its handler address on `disp_pc` and its line on `disp_line`. These values hold until the next dispatch.
- R4: Observations are dispatched in arrival order, oldest first.
- R5: A dispatch goes to the idle unit with the lowest index, where bit i of every unit vector belongs to unit i.
- R6: At most one start pulse is given per cycle. It is never given to a busy unit, and the started unit reads busy from the pulse cycle onward.
- R7: A completion pulse on a busy unit clears its busy bit at that clock edge. The unit can receive a start pulse at the following edge.
- R8: A fault pulse on a busy unit ends it exactly as a completion pulse does.
- R9: The ring holds 40 observations. An arrival into a full ring in a cycle with no dispatch displaces the oldest stored entry. No ready or stall signal exists.
- R10: The drop counter increments by one for each displaced observation. An arrival into a full ring in a cycle that also dispatches causes no drop.
- R11: While the flush input is high, `unit_abort` shows every busy unit. At that edge the ring empties, all units become idle, no dispatch occurs and an arrival in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obs_valid | input | 1 | An observation is presented this cycle |
| obs_vaddr | input | 48 | Observed virtual address |
| obs_handler | input | 16 | Handler start address for the observation |
| obs_line | input | 64 | Cache line payload (zero when absent) |
| ctx_flush | input | 1 | Context-switch flush |
| unit_done | input | 12 | Per-unit completion pulse |
| unit_fault | input | 12 | Per-unit fault pulse |
| unit_start | output | 12 | One-hot start pulse |
| unit_busy | output | 12 | Per-unit busy state |
| unit_abort | output | 12 | Units killed by the flush this cycle |
| disp_pc | output | 16 | Handler address loaded into the started unit |
| disp_vaddr | output | 48 | Address loaded into the started unit |
| disp_line | output | 64 | Line loaded into the started unit |
| drop_count | output | 16 | Displaced observation count, wraps |

## Verification
The assertions check the following on every cycle:
- start pulses are one-hot or zero, and a start never targets a busy unit;
- the chosen unit has no idle unit below it;
- finished or faulted units are free at the next edge;
- the ring count stays within its depth;
- the drop counter steps after each displacement;
- a flush leaves the ring and the pool empty.

Only the bench scenarios can show arrival-order dispatch and exactly which entry a full ring displaces. They also show that a pop and a push in the same cycle on a full ring lose nothing, and that an observation arriving during a flush never reaches a unit.

// File: rtl/obsq_pkg.sv
package obsq_pkg;
  localparam int ADDR_W = 48;
  localparam int PC_W   = 16;
  localparam int LINE_W = 64;

  typedef struct packed {
    logic [ADDR_W-1:0] vaddr;
    logic [PC_W-1:0]   handler;
    logic [LINE_W-1:0] line;
  } obs_rec_t;
endpackage

// File: rtl/obsq_ring.sv
module obsq_ring
  import obsq_pkg::*;
#(
  parameter int DEPTH = 40
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  logic     pop,
  input  logic     flush,
  input  obs_rec_t din,
  output obs_rec_t dout,
  output logic     empty,
  output logic     full,
  output logic     displaced
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  obs_rec_t        slots [DEPTH];
  logic [PW-1:0]   rd_q, rd_n, wr_q, wr_n;
  logic [CW-1:0]   cnt_q, cnt_n;
  logic            do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
  assign do_push   = push & ~flush;
  assign do_pop    = pop & ~empty & ~flush;
  assign displaced = do_push & full & ~do_pop;
  assign dout      = slots[rd_q];

  always_comb begin
    rd_n  = rd_q;
    wr_n  = wr_q;
    cnt_n = cnt_q;
    if (flush) begin
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else begin
      if (do_pop || displaced) rd_n = step(rd_q);
      if (do_push)             wr_n = step(wr_q);
      if (do_push && !do_pop && !full) cnt_n = cnt_q + CW'(1);
      else if (do_pop && !do_push)     cnt_n = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_n;
      wr_q  <= wr_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_q] <= din;
  end

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  a_r9_displace_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    displaced |=> full);
  a_r11_ring_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/unit_pick.sv
module unit_pick #(
  parameter int N = 12
) (
  input  logic [N-1:0] idle,
  output logic [N-1:0] grant,
  output logic         any_idle
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]    = idle[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | idle[i];
  end

  assign any_idle = seen[N];
endmodule

// File: rtl/unit_pool.sv
module unit_pool #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [N-1:0] grant,
  input  logic [N-1:0] done,
  input  logic [N-1:0] fault,
  input  logic         flush,
  output logic [N-1:0] busy,
  output logic [N-1:0] start,
  output logic [N-1:0] abort
);
  logic [N-1:0] busy_q, busy_n, start_q, start_n, ends;

  assign ends  = (done | fault) & busy_q;
  assign abort = flush ? busy_q : '0;

  always_comb begin
    busy_n  = busy_q & ~ends;
    start_n = '0;
    if (flush) begin
      busy_n = '0;
    end else if (go) begin
      busy_n  = busy_n | grant;
      start_n = grant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      start_q <= '0;
    end else begin
      busy_q  <= busy_n;
      start_q <= start_n;
    end
  end

  assign busy  = busy_q;
  assign start = start_q;

  a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_q));
  a_r6_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q & ~busy_q) == '0);
  a_r6_grant_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> ((grant & busy_q) == '0));
  a_r5_lowest_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (((grant - N'(1)) & ~busy_q) == '0));
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ends != '0 && !flush) |=> ((busy_q & $past(ends)) == '0));
  a_r11_pool_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_q == '0 && start_q == '0));
endmodule

// File: rtl/obs_dispatch.sv
module obs_dispatch
  import obsq_pkg::*;
#(
  parameter int DEPTH  = 40,
  parameter int NUNITS = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_valid,
  input  logic [ADDR_W-1:0] obs_vaddr,
  input  logic [PC_W-1:0]   obs_handler,
  input  logic [LINE_W-1:0] obs_line,
  input  logic              ctx_flush,
  input  logic [NUNITS-1:0] unit_done,
  input  logic [NUNITS-1:0] unit_fault,
  output logic [NUNITS-1:0] unit_start,
  output logic [NUNITS-1:0] unit_busy,
  output logic [NUNITS-1:0] unit_abort,
  output logic [PC_W-1:0]   disp_pc,
  output logic [ADDR_W-1:0] disp_vaddr,
  output logic [LINE_W-1:0] disp_line,
  output logic [CNT_W-1:0]  drop_count
);
  obs_rec_t          in_rec, head;
  logic              ring_empty, ring_full, displaced, any_idle, go;
  logic [NUNITS-1:0] grant, busy;
  logic [CNT_W-1:0]  drop_q, drop_n;
  obs_rec_t          disp_q, disp_n;

  assign in_rec = '{vaddr: obs_vaddr, handler: obs_handler, line: obs_line};

  obsq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (obs_valid),
    .pop       (go),
    .flush     (ctx_flush),
    .din       (in_rec),
    .dout      (head),
    .empty     (ring_empty),
    .full      (ring_full),
    .displaced (displaced)
  );

  unit_pick #(.N(NUNITS)) u_pick (
    .idle     (~busy),
    .grant    (grant),
    .any_idle (any_idle)
  );

  assign go = ~ring_empty & any_idle & ~ctx_flush;

  unit_pool #(.N(NUNITS)) u_pool (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .grant (grant),
    .done  (unit_done),
    .fault (unit_fault),
    .flush (ctx_flush),
    .busy  (busy),
    .start (unit_start),
    .abort (unit_abort)
  );

  always_comb begin
    disp_n = disp_q;
    if (go) disp_n = head;
    drop_n = drop_q;
    if (displaced) drop_n = drop_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      disp_q <= '0;
      drop_q <= '0;
    end else begin
      disp_q <= disp_n;
      drop_q <= drop_n;
    end
  end

  assign unit_busy  = busy;
  assign disp_pc    = disp_q.handler;
  assign disp_vaddr = disp_q.vaddr;
  assign disp_line  = disp_q.line;
  assign drop_count = drop_q;

  a_r10_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
    displaced |=> drop_count == $past(drop_count) + CNT_W'(1));
  a_r10_no_drop_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (go && ring_full && obs_valid) |=> $stable(drop_count));
  a_r9_full_no_dispatch_without_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ring_full && !any_idle && !ctx_flush) |=> (unit_start == '0));
endmodule

// File: tb/obs_dispatch_bench.sv
module obs_dispatch_bench;
  import obsq_pkg::*;

  localparam int N = 12;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              obs_valid;
  logic [ADDR_W-1:0] obs_vaddr;
  logic [PC_W-1:0]   obs_handler;
  logic [LINE_W-1:0] obs_line;
  logic              ctx_flush;
  logic [N-1:0]      unit_done, unit_fault;
  logic [N-1:0]      unit_start, unit_busy, unit_abort;
  logic [PC_W-1:0]   disp_pc;
  logic [ADDR_W-1:0] disp_vaddr;
  logic [LINE_W-1:0] disp_line;
  logic [15:0]       drop_count;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  obs_dispatch u_obs_dispatch (
    .clk(clk), .rst_n(rst_n), .obs_valid(obs_valid), .obs_vaddr(obs_vaddr),
    .obs_handler(obs_handler), .obs_line(obs_line), .ctx_flush(ctx_flush),
    .unit_done(unit_done), .unit_fault(unit_fault), .unit_start(unit_start),
    .unit_busy(unit_busy), .unit_abort(unit_abort), .disp_pc(disp_pc),
    .disp_vaddr(disp_vaddr), .disp_line(disp_line), .drop_count(drop_count)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    obs_valid = 1'b0; obs_vaddr = '0; obs_handler = '0; obs_line = '0;
    ctx_flush = 1'b0; unit_done = '0; unit_fault = '0;
    rst_n = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic push(input logic [ADDR_W-1:0] a);
    obs_valid   = 1'b1;
    obs_vaddr   = a;
    obs_handler = a[15:0] ^ 16'h5a00;
    obs_line    = {a[31:0], ~a[31:0]};
    tick();
    obs_valid = 1'b0;
  endtask

  task automatic fill_units(input int n);
    for (int i = 0; i < n; i++) push(48'h100 + 48'(i));
    tick();
  endtask

  task automatic pulse_done(input int idx);
    unit_done[idx] = 1'b1;
    tick();
    unit_done = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 busy after reset", 128'(unit_busy), 128'(0));
    chk("R1 start after reset", 128'(unit_start), 128'(0));
    chk("R1 abort after reset", 128'(unit_abort), 128'(0));
    chk("R1 drops after reset", 128'(drop_count), 128'(0));
  endtask

  task automatic t_single();
    do_reset();
    push(48'hABC_1234_5678);
    chk("R2 no start at accept edge", 128'(unit_start), 128'(0));
    tick();
    chk("R2 start unit0", 128'(unit_start), 128'(1));
    chk("R3 vaddr", 128'(disp_vaddr), 128'(48'hABC_1234_5678));
    chk("R3 handler", 128'(disp_pc), 128'(16'h5678 ^ 16'h5a00));
    chk("R3 line", 128'(disp_line), 128'({32'h1234_5678, ~32'h1234_5678}));
    chk("R6 unit0 busy", 128'(unit_busy), 128'(1));
    tick();
    chk("R2 pulse one cycle", 128'(unit_start), 128'(0));
    chk("R3 payload held", 128'(disp_vaddr), 128'(48'hABC_1234_5678));
  endtask

  task automatic t_order();
    do_reset();
    fill_units(1);
    push(48'hB0);
    chk("R6 nothing yet", 128'(unit_start), 128'(0));
    push(48'hB1);
    chk("R5 first to unit1", 128'(unit_start), 128'(12'h002));
    chk("R4 oldest first", 128'(disp_vaddr), 128'(48'hB0));
    push(48'hB2);
    chk("R5 second to unit2", 128'(unit_start), 128'(12'h004));
    chk("R4 second in order", 128'(disp_vaddr), 128'(48'hB1));
    tick();
    chk("R5 third to unit3", 128'(unit_start), 128'(12'h008));
    chk("R4 third in order", 128'(disp_vaddr), 128'(48'hB2));
    chk("R6 four busy", 128'(unit_busy), 128'(12'h00F));
  endtask

  task automatic t_release();
    do_reset();
    fill_units(4);
    pulse_done(1);
    chk("R7 done frees unit1", 128'(unit_busy), 128'(12'h00D));
    push(48'h55);
    tick();
    chk("R7 freed unit reused", 128'(unit_start), 128'(12'h002));
    unit_fault[2] = 1'b1;
    tick();
    unit_fault = '0;
    chk("R8 fault frees unit2", 128'(unit_busy), 128'(12'h00B));
    push(48'h66);
    tick();
    chk("R8 faulted unit reused", 128'(unit_start), 128'(12'h004));
    chk("R8 payload", 128'(disp_vaddr), 128'(48'h66));
  endtask

  task automatic t_overflow();
    do_reset();
    fill_units(N);
    chk("R6 all busy", 128'(unit_busy), 128'(12'hFFF));
    for (int k = 0; k < 43; k++) push(48'h1000 + 48'(k));
    chk("R10 three drops", 128'(drop_count), 128'(3));
    chk("R9 no dispatch while pool busy", 128'(unit_start), 128'(0));
    pulse_done(7);
    chk("R7 unit7 free same edge", 128'(unit_busy[7]), 128'(0));
    chk("R7 no start yet", 128'(unit_start), 128'(0));
    push(48'h2000);
    chk("R7 next-edge start unit7", 128'(unit_start), 128'(12'h080));
    chk("R9 oldest three displaced", 128'(disp_vaddr), 128'(48'h1003));
    chk("R10 no drop with pop", 128'(drop_count), 128'(3));
    pulse_done(2);
    tick();
    chk("R4 next survivor", 128'(disp_vaddr), 128'(48'h1004));
    chk("R5 unit2 chosen", 128'(unit_start), 128'(12'h004));
  endtask

  task automatic t_flush();
    do_reset();
    fill_units(N);
    for (int k = 0; k < 5; k++) push(48'h3000 + 48'(k));
    ctx_flush   = 1'b1;
    obs_valid   = 1'b1;
    obs_vaddr   = 48'h777;
    #1;
    chk("R11 abort shows busy", 128'(unit_abort), 128'(12'hFFF));
    tick();
    ctx_flush = 1'b0;
    obs_valid = 1'b0;
    #1;
    chk("R11 pool idle", 128'(unit_busy), 128'(0));
    chk("R11 abort cleared", 128'(unit_abort), 128'(0));
    for (int c = 0; c < 3; c++) begin
      tick();
      chk("R11 ring empty, no start", 128'(unit_start), 128'(0));
    end
    push(48'h888);
    tick();
    chk("R11 fresh entry only", 128'(disp_vaddr), 128'(48'h888));
    chk("R11 unit0 after flush", 128'(unit_start), 128'(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_order();
    t_release();
    t_overflow();
    t_flush();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule